// File: doc/BRIEF.md
# Software-Driven Management Serial Port

This block gives a host processor direct, bit-level control over a three-wire management bus for PHY devices. The bus carries a bidirectional data line, a clock line and an active-low PHY reset line. The host writes one 32-bit control word over a simple register bus. Each field of that word sets one pin: the data level, the data direction, the clock level, the reset level and a master enable. All waveform timing and frame structure come from software. The block itself never toggles a pin.

The data line is open-drain in use, and an external pull-up holds it high when nothing drives it. Reads of the control word return the live data-line level after a two-flop synchronizer, so software can sample a PHY's reply bits with the same register it uses to drive the line. Clearing the master enable releases all three pins at once, so another bus master can take over without contention.

Top module: `mgmt_bitbang_port`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, `mdio_oe`, `mdc_oe` and `phy_rst_oe` are 0 and the stored fields read back as 0.
- R2: The control word changes only on a cycle with `reg_sel`=1, `reg_wr`=1 and `reg_addr`=0x08. Writes to any other address, and cycles with `reg_wr`=0, leave every output pin and every read-back field unchanged.
- R3: When the master enable (bit 4) and the transmit enable (bit 2) are both 1, `mdio_oe` is 1 and `mdio_o` equals the written data bit (bit 0), starting from the cycle after the write.
- R4: When bit 4 is 1 and bit 2 is 0, `mdio_oe` is 0 while `mdc_oe` and `phy_rst_oe` stay 1.
- R5: When bit 4 is 0, `mdio_oe`, `mdc_oe` and `phy_rst_oe` are all 0, whatever the other bits hold.
- R6: When bit 4 is 1, `mdc_o` equals the written clock bit (bit 1).
- R7: When bit 4 is 1, `phy_rst_n_o` is the inverse of the written reset bit (bit 3): writing 1 to bit 3 drives the line low, which puts the PHY in reset.
- R8: Bit 0 of a read returns the data-line level `mdio_i` seen through two flops. After the clock edge n, it shows the level present at edge n-1. It never returns the written data bit directly.
- R9: A read at 0x08 returns bits 1 to 4 as last written and zeros in bits 31 to 5. A read at any other address, or with `reg_sel` low, returns all zeros.
- R10: The output pins and their enables change only in the cycle after an accepted write. Idle or read cycles produce no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register-bus select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset within the device I/O space |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on the current access |
| mdio_i | input | 1 | Sensed level of the data line |
| mdio_o | output | 1 | Level driven on the data line |
| mdio_oe | output | 1 | Data-line output enable |
| mdc_o | output | 1 | Management clock level |
| mdc_oe | output | 1 | Management clock output enable |
| phy_rst_n_o | output | 1 | Active-low PHY reset level |
| phy_rst_oe | output | 1 | PHY reset output enable |

## Verification
The bench runs a software-style frame. It toggles the clock bit while it shifts a pseudo-random bit pattern onto the data line. It then releases the line and reads back bits that a modelled PHY drives. This separates a read-back taken from the pin from one taken from the written bit. A phase with the line released and nobody driving it shows that the pull-up level reaches the read path. Master-enable toggles with the other bits set to 1 show that all three pins float together. Writes to wrong offsets, and reads mixed among writes, show that only the decoded offset has any effect and that no pin moves on its own.

// File: rtl/mgmt_bitbang_port.sv
module mgmt_bitbang_port #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              mdc_o,
  output logic              mdc_oe,
  output logic              phy_rst_n_o,
  output logic              phy_rst_oe
);

  localparam int B_DATA = 0;
  localparam int B_CLK  = 1;
  localparam int B_TXEN = 2;
  localparam int B_RST  = 3;
  localparam int B_EN   = 4;
  localparam int NFIELD = 5;

  logic [NFIELD-1:0] ctrl;
  logic              sync1, sync2;
  logic              hit, wr_hit, rd_hit;
  logic              unused_hi;

  assign hit    = reg_sel && (reg_addr == ADDR_W'(REG_OFFSET));
  assign wr_hit = hit && reg_wr;
  assign rd_hit = hit && !reg_wr;
  assign unused_hi = ^reg_wdata[DATA_W-1:NFIELD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl <= '0;
    else if (wr_hit) ctrl <= reg_wdata[NFIELD-1:0];
  end

  always_ff @(posedge clk) begin
    sync1 <= mdio_i;
    sync2 <= sync1;
  end

  assign mdio_o      = ctrl[B_DATA];
  assign mdio_oe     = ctrl[B_EN] & ctrl[B_TXEN];
  assign mdc_o       = ctrl[B_CLK];
  assign mdc_oe      = ctrl[B_EN];
  assign phy_rst_n_o = ~ctrl[B_RST];
  assign phy_rst_oe  = ctrl[B_EN];

  assign reg_rdata = rd_hit ? DATA_W'({ctrl[NFIELD-1:1], sync2}) : '0;

  AST_RESET_RELEASED: assert property (@(posedge clk)
    $rose(rst_n) |-> !mdio_oe && !mdc_oe && !phy_rst_oe); // R1

  AST_DRIVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit && reg_wdata[B_EN] && reg_wdata[B_TXEN])
      |-> mdio_oe && (mdio_o == $past(reg_wdata[B_DATA]))); // R3

  AST_DATA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit && reg_wdata[B_EN] && !reg_wdata[B_TXEN])
      |-> !mdio_oe && mdc_oe && phy_rst_oe); // R4

  AST_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit && !reg_wdata[B_EN]) |-> !mdio_oe && !mdc_oe && !phy_rst_oe); // R5

  AST_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> mdc_o == $past(reg_wdata[B_CLK])); // R6

  AST_RST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> phy_rst_n_o == !$past(reg_wdata[B_RST])); // R7

  AST_PIN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> reg_rdata[0] == $past(mdio_i, 2)); // R8

  AST_NO_SELF_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> $stable({mdio_o, mdio_oe, mdc_o, mdc_oe, phy_rst_n_o, phy_rst_oe})); // R10

endmodule

// File: tb/tb_mgmt_bitbang_port.sv
`timescale 1ns/1ps
module tb_mgmt_bitbang_port;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic mdio_o, mdio_oe, mdc_o, mdc_oe, phy_rst_n_o, phy_rst_oe;
  logic phy_drive = 1'b0, phy_val = 1'b0;
  logic line;

  always #2 clk = ~clk;

  // open-drain line with pull-up
  assign line = mdio_oe ? mdio_o : (phy_drive ? phy_val : 1'b1);

  mgmt_bitbang_port dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdc_o(mdc_o),
    .mdc_oe(mdc_oe), .phy_rst_n_o(phy_rst_n_o), .phy_rst_oe(phy_rst_oe)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit m_d = 0, m_clk = 0, m_tx = 0, m_rst = 0, m_en = 0;
  bit hist[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model stepped once per cycle, compared away from the active edge
  always @(negedge clk) begin
    bit pre;
    logic [DATA_W-1:0] exp_rd;
    cycles++;
    pre = (m_en && m_tx) ? m_d : (phy_drive ? phy_val : 1'b1);
    hist.push_front(pre);
    if (hist.size() > 4) void'(hist.pop_back());
    if (!rst_n) begin
      {m_d, m_clk, m_tx, m_rst, m_en} = '0;
    end else if (reg_sel && reg_wr && reg_addr == 8'h08) begin
      m_d = reg_wdata[0]; m_clk = reg_wdata[1]; m_tx = reg_wdata[2];
      m_rst = reg_wdata[3]; m_en = reg_wdata[4];
    end
    chk(mdio_oe === (m_en && m_tx), m_en ? "R3/R4 mdio_oe" : "R1/R5 mdio_oe", 32'(mdio_oe), 32'(m_en && m_tx));
    chk(mdc_oe === m_en, "R1/R5 mdc_oe", 32'(mdc_oe), 32'(m_en));
    chk(phy_rst_oe === m_en, "R1/R5 phy_rst_oe", 32'(phy_rst_oe), 32'(m_en));
    if (m_en && m_tx) chk(mdio_o === m_d, "R3 mdio_o", 32'(mdio_o), 32'(m_d));
    if (m_en) begin
      chk(mdc_o === m_clk, "R6 mdc_o", 32'(mdc_o), 32'(m_clk));
      chk(phy_rst_n_o === !m_rst, "R7 phy_rst_n_o", 32'(phy_rst_n_o), 32'(!m_rst));
    end
    if (rst_n && hist.size() >= 2) begin
      if (reg_sel && !reg_wr && reg_addr == 8'h08)
        exp_rd = {27'd0, m_en, m_rst, m_tx, m_clk, hist[1]};
      else
        exp_rd = '0;
      chk(reg_rdata === exp_rd, "R8/R9 read data", reg_rdata, exp_rd);
    end
  end

  always @(posedge clk) begin
    if (!done && cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input bit s, input bit w, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
    @(negedge clk); #0.5;
    reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cyc(1, 1, a, d);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    cyc(1, 0, a, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0);
  endtask

  initial begin
    logic [31:0] lfsr;
    idle(3);
    rd(8'h08);                                   // R1 read during reset is not checked
    @(negedge clk); #0.5; rst_n = 1'b1;
    rd(8'h08); rd(8'h08);                        // R1 zeros after reset, R8 pull-up level
    wr(8'h08, 32'hFFFF_FFEF);                    // R5 enable clear with all else set
    rd(8'h08); idle(2); rd(8'h08);
    wr(8'h04, 32'h1F); wr(8'h0C, 32'h1F);        // R2 wrong offsets
    cyc(0, 1, 8'h08, 32'h1F);                    // R2 not selected
    idle(2); rd(8'h08); rd(8'h00);               // R9 other address reads zero
    wr(8'h08, 32'h17);                           // R3 drive 1, clk 1
    idle(3); rd(8'h08); rd(8'h08);
    wr(8'h08, 32'h1C);                           // R3 drive 0, R7 reset asserted
    idle(3); rd(8'h08);
    wr(8'h08, 32'h10);                           // R4 release, R8 pull-up
    idle(3); rd(8'h08);
    // R3/R6 software frame: shift pseudo-random bits with clock toggles
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 64; i++) begin
      wr(8'h08, {27'd0, 1'b1, 1'b0, 1'b1, 1'b0, lfsr[0]});
      rd(8'h08);
      wr(8'h08, {27'd0, 1'b1, 1'b0, 1'b1, 1'b1, lfsr[0]});
      idle(1); rd(8'h08);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end
    // R8 turnaround: release, modelled PHY drives reply bits
    wr(8'h08, 32'h11);                           // data bit 1 written, line released
    for (int i = 0; i < 32; i++) begin
      cyc(0, 0, '0, '0); phy_drive = 1'b1; phy_val = lfsr[i % 32];
      wr(8'h08, 32'h12);
      wr(8'h08, 32'h10);
      rd(8'h08); rd(8'h08); rd(8'h08);
    end
    phy_drive = 1'b0;
    // R5 hand-over while PHY drives low; R8 still senses the line
    wr(8'h08, 32'h0F);
    cyc(0, 0, '0, '0); phy_drive = 1'b1; phy_val = 1'b0;
    idle(2); rd(8'h08); rd(8'h08);
    phy_drive = 1'b0;
    idle(2); rd(8'h08);
    // R10 long idle and read-only stretch
    wr(8'h08, 32'h1E);
    for (int i = 0; i < 20; i++) rd(8'h08);
    idle(20);
    // R1 reset in the middle of operation
    @(negedge clk); #0.5; rst_n = 1'b0; reg_sel = 1'b0;
    idle(3);
    @(negedge clk); #0.5; rst_n = 1'b1;
    idle(2); rd(8'h08); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule